// File: doc/BRIEF.md
# Cascadable Time-Slot Serial Sample Transmitter

This block turns complex baseband samples from one or two receiver channels into a serial bit stream. Each frame fills one time slot. A frame holds the in-phase and quadrature words of channel A, or of channels A and B. An extra read-back word can follow them. Words are 16, 24 or 32 bits long and are sent MSB first. Sample bits come first and zero padding fills the rest of the word.

In master mode the block divides its system clock to make the bit clock. A frame starts after each sample strobe. In slave mode the bit clock and a slot-go input come from outside. Both are synchronised into the system clock domain, and the block acts on their detected edges. A master's last-bit output can drive a slave's slot-go input, so slots pass down a chain with no idle bit between them. The system clock must run at least four times as fast as an external bit clock.

Top module: `tslot_tx`

## Requirements
- R1: `word_sel` sets the word length: 00 gives 16 bits, 01 gives 24 bits and 10 gives 32 bits. Each word is sent MSB first, with the 24 sample bits at the front and zero padding after them. A 16-bit word carries the top 16 sample bits.
- R2: With `dual_ch` low a frame is two words, A-I then A-Q. With `dual_ch` high it is four words, A-I, A-Q, B-I, B-Q.
- R3: If `add_word` is high at frame start, one more word is sent last. It holds the pending read-back value, or zero when no read is pending.
- R4: A `rd_stb` pulse captures `rd_word` as a pending read. The next frame appends that value even when `add_word` is low, and this clears the pending read, so the frame after it has no extra word.
- R5: `slot_last` rises on the same bit-clock rising edge that drives the final bit of a frame. It is high for exactly that one bit period and falls at the next rising edge.
- R6: In master mode `bclk_out` stays high for max(`clk_div`,1) system clocks and low for the same number, which gives clk/(2*`clk_div`), or clk/2 when `clk_div` is 0.
- R7: In master mode a frame starts on the first bit-clock falling edge after a `smp_stb` pulse has been registered. Its first bit is driven at the next rising edge. `slot_go` has no effect in master mode.
- R8: In slave mode `slot_go` is sampled at each falling edge of `bclk_in`. When it is high the frame's first bit appears after the next rising edge of `bclk_in`. `clk_div` is ignored, `bclk_out` stays 0, and `ser_out` is 0 before the slot.
- R9: A `smp_stb` that arrives while a frame is shifting sets `overrun`. The flag stays set until reset.
- R10: With `word_sel` = 11, `word_err` is high, no frame starts, and `ser_out` and `slot_last` stay 0. `word_err` clears once the field holds a legal value.
- R11: Sample and read-back values are copied at frame start. Changing the sample inputs during a frame does not alter the words of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 = generate the bit clock, 0 = use the external bit clock |
| word_sel | input | 2 | Word length code |
| dual_ch | input | 1 | Send channel B as well as channel A |
| add_word | input | 1 | Append the read-back word |
| clk_div | input | 4 | Master bit-clock divider |
| a_i | input | 24 | Channel A in-phase sample |
| a_q | input | 24 | Channel A quadrature sample |
| b_i | input | 24 | Channel B in-phase sample |
| b_q | input | 24 | Channel B quadrature sample |
| smp_stb | input | 1 | New sample ready |
| rd_word | input | 32 | Register read-back value |
| rd_stb | input | 1 | `rd_word` is valid |
| bclk_in | input | 1 | External bit clock (slave) |
| slot_go | input | 1 | External slot start (slave) |
| bclk_out | output | 1 | Generated bit clock (master) |
| ser_out | output | 1 | Serial data |
| slot_last | output | 1 | Final bit period of the slot |
| overrun | output | 1 | Sticky sample overrun |
| word_err | output | 1 | Illegal word length selected |

## Verification
The main collision is a new sample strobe that lands while a frame is still shifting. In that cycle the overrun flag has to set while the current frame carries on untouched. The bench sends a second strobe into the middle of a 32-bit slot. It then checks that the flag sets, that it stays set long after the slot, and that it was clear before the second strobe. A second collision is a register read that is already pending when `add_word` is low. The bench checks the exact length and bit content of that frame and of the frame after it. In every random frame it also changes the sample inputs after the first bit, and the received stream must still match the values held at frame start.

// File: rtl/tslot_tx.sv
module tslot_tx #(
  parameter int SW   = 24,
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            master_en,
  input  logic [1:0]      word_sel,
  input  logic            dual_ch,
  input  logic            add_word,
  input  logic [DIVW-1:0] clk_div,
  input  logic [SW-1:0]   a_i,
  input  logic [SW-1:0]   a_q,
  input  logic [SW-1:0]   b_i,
  input  logic [SW-1:0]   b_q,
  input  logic            smp_stb,
  input  logic [31:0]     rd_word,
  input  logic            rd_stb,
  input  logic            bclk_in,
  input  logic            slot_go,
  output logic            bclk_out,
  output logic            ser_out,
  output logic            slot_last,
  output logic            overrun,
  output logic            word_err
);
  localparam int WMAX = 32;
  localparam int PADW = WMAX - SW;

  logic [DIVW-1:0]     hcnt, half;
  logic                bclk_q;
  logic [2:0]          bc_s;
  logic [1:0]          go_s;
  logic                busy, pend, rd_pend, err_q, ovr_q, out_q, last_q;
  logic [2:0]          widx, nw, nsmp, nxt;
  logic [5:0]          bcnt, wlen;
  logic [WMAX-1:0]     shreg, rd_buf, h_rd, nxt_word;
  logic [3:0][SW-1:0]  h_smp;
  logic                h_div, h_app;
  logic                tick, ev_rise, ev_fall, bad_sel, start, last_bit, last_word;

  assign half      = (clk_div == '0) ? DIVW'(1) : clk_div;
  assign tick      = master_en && (hcnt >= half - DIVW'(1));
  assign ev_rise   = master_en ? (tick & ~bclk_q) : (bc_s[1] & ~bc_s[2]);
  assign ev_fall   = master_en ? (tick & bclk_q)  : (~bc_s[1] & bc_s[2]);
  assign bad_sel   = (word_sel == 2'b11);
  assign start     = ev_fall & ~busy & ~bad_sel & (master_en ? pend : go_s[1]);
  assign nsmp      = h_div ? 3'd4 : 3'd2;
  assign nw        = nsmp + {2'b00, h_app};
  assign nxt       = widx + 3'd1;
  assign last_bit  = (bcnt == wlen - 6'd1);
  assign last_word = (widx == nw - 3'd1);
  assign nxt_word  = (nxt < nsmp) ? (WMAX'(h_smp[nxt[1:0]]) << PADW) : h_rd;

  always_comb begin
    case (word_sel)
      2'b00:   wlen = 6'd16;
      2'b01:   wlen = 6'd24;
      default: wlen = 6'd32;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt   <= '0;
      bclk_q <= 1'b0;
    end else if (!master_en) begin
      hcnt   <= '0;
      bclk_q <= 1'b0;
    end else if (tick) begin
      hcnt   <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      hcnt   <= hcnt + DIVW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_s <= '0;
      go_s <= '0;
    end else begin
      bc_s <= {bc_s[1:0], bclk_in};
      go_s <= {go_s[0], slot_go};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      pend    <= 1'b0;
      rd_pend <= 1'b0;
      rd_buf  <= '0;
      err_q   <= 1'b0;
      ovr_q   <= 1'b0;
      out_q   <= 1'b0;
      last_q  <= 1'b0;
      widx    <= '0;
      bcnt    <= '0;
      shreg   <= '0;
      h_smp   <= '0;
      h_rd    <= '0;
      h_div   <= 1'b0;
      h_app   <= 1'b0;
    end else begin
      err_q   <= bad_sel;
      rd_pend <= (rd_pend & ~start) | rd_stb;
      if (rd_stb) rd_buf <= rd_word;
      pend    <= master_en & ((pend & ~start) | smp_stb);
      if (smp_stb && busy) ovr_q <= 1'b1;

      if (bad_sel) begin
        busy   <= 1'b0;
        out_q  <= 1'b0;
        last_q <= 1'b0;
      end else if (start) begin
        busy  <= 1'b1;
        widx  <= '0;
        bcnt  <= '0;
        shreg <= WMAX'(a_i) << PADW;
        h_smp <= {b_q, b_i, a_q, a_i};
        h_rd  <= rd_pend ? rd_buf : '0;
        h_div <= dual_ch;
        h_app <= add_word | rd_pend;
      end else if (ev_rise) begin
        if (busy) begin
          out_q  <= shreg[WMAX-1];
          last_q <= last_bit & last_word;
          if (last_bit) begin
            bcnt  <= '0;
            widx  <= nxt;
            shreg <= nxt_word;
            if (last_word) busy <= 1'b0;
          end else begin
            bcnt  <= bcnt + 6'd1;
            shreg <= shreg << 1;
          end
        end else begin
          out_q  <= 1'b0;
          last_q <= 1'b0;
        end
      end
    end
  end

  assign bclk_out  = master_en & bclk_q;
  assign ser_out   = out_q;
  assign slot_last = last_q;
  assign overrun   = ovr_q;
  assign word_err  = err_q;

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overrun |=> overrun); // R9
  AST_BAD_SEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n) word_err |-> (!ser_out && !slot_last)); // R10
  AST_LAST_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) (master_en && $rose(slot_last)) |-> bclk_out); // R5
  AST_DATA_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) $rose(ser_out) |-> $past(busy)); // R7
endmodule

// File: tb/tslot_tx_bench.sv
module tslot_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        master_en = 1'b1;
  logic [1:0]  word_sel = 2'b00;
  logic        dual_ch = 1'b0, add_word = 1'b0;
  logic [3:0]  clk_div = 4'd0;
  logic [23:0] a_i = '0, a_q = '0, b_i = '0, b_q = '0;
  logic        smp_stb = 1'b0;
  logic [31:0] rd_word = '0;
  logic        rd_stb = 1'b0;
  logic        bclk_in = 1'b0, slot_go = 1'b0;
  wire         bclk_out, ser_out, slot_last, overrun, word_err;

  tslot_tx u_tslot_tx (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .word_sel(word_sel),
    .dual_ch(dual_ch), .add_word(add_word), .clk_div(clk_div),
    .a_i(a_i), .a_q(a_q), .b_i(b_i), .b_q(b_q), .smp_stb(smp_stb),
    .rd_word(rd_word), .rd_stb(rd_stb), .bclk_in(bclk_in), .slot_go(slot_go),
    .bclk_out(bclk_out), .ser_out(ser_out), .slot_last(slot_last),
    .overrun(overrun), .word_err(word_err)
  );

  int nvec = 0, nbad = 0, cyc = 0, fe_hits = 0;
  bit exp_q[$];
  bit got_q[$];
  bit m_rdp = 1'b0;
  logic [31:0] m_rdbuf = '0;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nbad++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic scramble();
    a_i = 24'($urandom); a_q = 24'($urandom);
    b_i = 24'($urandom); b_q = 24'($urandom);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_rdp = 1'b0;
    @(negedge clk);
  endtask

  task automatic build_exp(input logic [1:0] w, input bit dv, input bit ap, input logic [31:0] rw);
    int wl_n;
    int n;
    logic [31:0] words [5];
    wl_n = (w == 2'b00) ? 16 : (w == 2'b01) ? 24 : 32;
    words[0] = {a_i, 8'h00};
    words[1] = {a_q, 8'h00};
    n = 2;
    if (dv) begin
      words[2] = {b_i, 8'h00};
      words[3] = {b_q, 8'h00};
      n = 4;
    end
    if (ap) begin
      words[n] = rw;
      n++;
    end
    exp_q.delete();
    for (int k = 0; k < n; k++)
      for (int b = 0; b < wl_n; b++)
        exp_q.push_back(words[k][31-b]);
  endtask

  task automatic cmp_stream(input string tag);
    int bad_i;
    int lim;
    bad_i = -1;
    lim = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    chk(got_q.size() == exp_q.size(), {tag, " frame length"}, got_q.size(), exp_q.size());
    for (int i = 0; i < lim; i++)
      if (got_q[i] != exp_q[i] && bad_i < 0) bad_i = i;
    if (bad_i >= 0)
      chk(1'b0, $sformatf("%s bit %0d", tag, bad_i), got_q[bad_i], exp_q[bad_i]);
    else
      chk(1'b1, tag, 0, 0);
    chk(fe_hits == 1, "R5 slot_last count in frame", fe_hits, 1);
  endtask

  task automatic collect_m();
    bit prev;
    bit started;
    int guard;
    got_q.delete();
    fe_hits = 0;
    prev = bclk_out;
    started = 0;
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (guard > 5000) break;
      if (!started) begin
        if (prev && !bclk_out) started = 1;
      end else if (!prev && bclk_out) begin
        got_q.push_back(ser_out);
        if (slot_last) fe_hits++;
        if (got_q.size() == 1) scramble();
        if (slot_last) break;
      end
      prev = bclk_out;
    end
    prev = bclk_out;
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if ((!prev && bclk_out) || guard > 200) break;
      prev = bclk_out;
    end
    chk(slot_last == 1'b0, "R5 slot_last falls at next rising edge", slot_last, 0);
  endtask

  task automatic collect_s();
    bit sclk_bad;
    got_q.delete();
    fe_hits = 0;
    sclk_bad = 0;
    bclk_in = 1'b0;
    repeat (4) @(negedge clk);
    bclk_in = 1'b1;
    slot_go = 1'b1;
    repeat (4) @(negedge clk);
    chk(ser_out == 1'b0 && slot_last == 1'b0, "R8 idle before slot", {ser_out, slot_last}, 0);
    bclk_in = 1'b0;
    repeat (4) @(negedge clk);
    for (int g = 0; g < 200; g++) begin
      bclk_in = 1'b1;
      slot_go = 1'b0;
      repeat (4) @(negedge clk);
      got_q.push_back(ser_out);
      if (slot_last) fe_hits++;
      if (bclk_out) sclk_bad = 1;
      if (g == 0) scramble();
      bclk_in = 1'b0;
      repeat (4) @(negedge clk);
      if (slot_last) break;
    end
    bclk_in = 1'b1;
    repeat (4) @(negedge clk);
    chk(slot_last == 1'b0, "R5 slave slot_last falls at next rising edge", slot_last, 0);
    bclk_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(!sclk_bad, "R8 bclk_out held low in slave mode", sclk_bad, 0);
  endtask

  task automatic prep(input logic [1:0] w, input bit dv, input bit ap, input logic [3:0] sd,
                      input bit do_rd, input logic [31:0] rdw);
    word_sel = w;
    dual_ch = dv;
    add_word = ap;
    clk_div = sd;
    if (do_rd) begin
      @(negedge clk);
      rd_word = rdw;
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      m_rdp = 1'b1;
      m_rdbuf = rdw;
    end
    build_exp(w, dv, ap | m_rdp, m_rdp ? m_rdbuf : 32'h0);
    m_rdp = 1'b0;
  endtask

  task automatic run_master(input logic [1:0] w, input bit dv, input bit ap, input logic [3:0] sd,
                            input bit do_rd, input logic [31:0] rdw, input string tag);
    prep(w, dv, ap, sd, do_rd, rdw);
    @(negedge clk);
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    collect_m();
    cmp_stream(tag);
  endtask

  task automatic run_slave(input logic [1:0] w, input bit dv, input bit ap,
                           input bit do_rd, input logic [31:0] rdw, input string tag);
    prep(w, dv, ap, 4'($urandom), do_rd, rdw);
    collect_s();
    cmp_stream(tag);
  endtask

  task automatic measure(input logic [3:0] sd, output int hi, output int lo);
    clk_div = sd;
    repeat (12) @(negedge clk);
    do @(negedge clk); while (bclk_out);
    do @(negedge clk); while (!bclk_out);
    hi = 0;
    while (bclk_out) begin hi++; @(negedge clk); end
    lo = 0;
    while (!bclk_out) begin lo++; @(negedge clk); end
  endtask

  initial begin
    int hi, lo;
    bit seen;
    void'($urandom(32'h1F2E3D));

    repeat (2) @(negedge clk);
    chk(ser_out == 0 && slot_last == 0, "R5 reset outputs", {ser_out, slot_last}, 0);
    chk(overrun == 0, "R9 reset overrun", overrun, 0);
    chk(word_err == 0 && bclk_out == 0, "R10 reset word_err", {word_err, bclk_out}, 0);
    rst_n = 1'b1;

    measure(4'd3, hi, lo);
    chk(hi == 3 && lo == 3, "R6 half periods clk_div=3", {hi[15:0], lo[15:0]}, {16'd3, 16'd3});
    measure(4'd0, hi, lo);
    chk(hi == 1 && lo == 1, "R6 half periods clk_div=0", {hi[15:0], lo[15:0]}, {16'd1, 16'd1});
    measure(4'd5, hi, lo);
    chk(hi == 5 && lo == 5, "R6 half periods clk_div=5", {hi[15:0], lo[15:0]}, {16'd5, 16'd5});

    do_reset();
    a_i = 24'h800001; a_q = 24'h7FFFFE; b_i = 24'hC3A55A; b_q = 24'h0F00F1;
    run_master(2'b00, 0, 0, 4'd1, 0, 0, "R1 R2 16-bit single channel");
    a_i = 24'h123456; a_q = 24'hFEDCBA; b_i = 24'h00FF00; b_q = 24'hAAAAAB;
    run_master(2'b01, 1, 0, 4'd0, 0, 0, "R1 R2 24-bit dual channel");
    a_i = 24'hFFFFFF; a_q = 24'h000001;
    run_master(2'b10, 0, 1, 4'd2, 0, 0, "R3 32-bit with zero appended word");
    run_master(2'b10, 0, 0, 4'd0, 1, 32'hA5C30F96, "R4 pending read appended");
    run_master(2'b01, 0, 0, 4'd0, 0, 0, "R4 read consumed no extra word");
    run_master(2'b00, 1, 1, 4'd1, 1, 32'h5A5A1234, "R3 R4 append with read in dual");

    for (int it = 0; it < 16; it++) begin
      scramble();
      slot_go = 1'($urandom);
      run_master(2'($urandom % 3), 1'($urandom), 1'($urandom), 4'($urandom % 4),
                 ($urandom % 3) == 0, $urandom, "R7 R11 random master frame");
    end
    slot_go = 1'b0;

    do_reset();
    word_sel = 2'b10; dual_ch = 0; add_word = 0; clk_div = 4'd0;
    @(negedge clk); smp_stb = 1'b1; @(negedge clk); smp_stb = 1'b0;
    repeat (20) @(negedge clk);
    chk(overrun == 0, "R9 no overrun before second strobe", overrun, 0);
    smp_stb = 1'b1; @(negedge clk); smp_stb = 1'b0;
    chk(overrun == 1, "R9 overrun set by strobe during frame", overrun, 1);
    repeat (400) @(negedge clk);
    chk(overrun == 1, "R9 overrun sticky", overrun, 1);

    do_reset();
    word_sel = 2'b11; clk_div = 4'd0;
    @(negedge clk); smp_stb = 1'b1; @(negedge clk); smp_stb = 1'b0;
    seen = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (ser_out || slot_last) seen = 1;
    end
    chk(!seen, "R10 nothing sent with word_sel=11", seen, 0);
    chk(word_err == 1, "R10 word_err high", word_err, 1);
    word_sel = 2'b00;
    repeat (3) @(negedge clk);
    chk(word_err == 0, "R10 word_err clears", word_err, 0);

    master_en = 1'b0;
    do_reset();
    scramble();
    run_slave(2'b01, 1, 0, 0, 0, "R8 slave 24-bit dual");
    scramble();
    run_slave(2'b00, 0, 1, 1, 32'hDEADBEEF, "R8 slave 16-bit with read");
    scramble();
    run_slave(2'b10, 0, 0, 0, 0, "R8 R11 slave 32-bit single");

    finish_run();
  end
endmodule